// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block is the interrupt unit that sits beside the control path of a small 8-bit processor core. It watches five request lines: a non-maskable trap, three maskable vectored restart lines (R7.5, R6.5, R5.5) and a maskable general request with no vector. It also watches a bus-hold request. Each line has its own kind of trigger. The trap needs a rising edge and must still be high when it is taken. R7.5 latches a rising edge. R6.5, R5.5 and the general request are plain levels. The block then applies a global enable, one mask per restart line and a fixed priority.

The core raises `sample_pt` for one cycle at its instruction boundary. That is the second T-state of the last machine cycle. At that edge, and only then, the controller decides. A pending hold request moves the state machine to the hold-granted state, ahead of any interrupt. Otherwise the winning vectored request is reported with its 16-bit vector address. If the general request wins instead, the state machine enters the acknowledge state and drives an active-low acknowledge, one cycle for each opcode byte. Every recognition clears the global enable. The core writes a set-mask byte and can read a status byte at any time.

State machine: `S_IDLE` (waits for the sample point), `S_HOLD` (bus granted while the hold request stays high), `S_ACK` (acknowledge cycles for the general request). The transitions are:
- `IDLE_TO_HOLD`: at a sample point with the hold request high.
- `IDLE_TO_ACK`: at a sample point where the general request wins.
- `HOLD_TO_IDLE`: when the hold request drops.
- `ACK_STAY`: another byte is requested and the count is below the limit.
- `ACK_TO_IDLE`: otherwise.

A vectored recognition stays in `S_IDLE`.

Top module: `vint_ctrl`

## Requirements
- R1: After reset, `vec_vld` is 0, `inta_n` is 1 and `hold_gnt` is 0. `stat_byte` reads 0x07 while all request inputs are low: nothing pending, enable 0, all three masks set.
- R2: Requests are evaluated only at a rising edge where `sample_pt` is 1 and the state is `S_IDLE`. A vectored recognition raises `vec_vld` for exactly one cycle after that edge, with the vector on `vec_addr`.
- R3: The fixed priority, highest first, is: trap (vector 0x0024), R7.5 (0x003C), R6.5 (0x0034), R5.5 (0x002C), then the general request. Each vector is the doubled restart number times `STRIDE/2`.
- R4: The trap ignores the global enable and all masks. It is taken only if a rising edge was seen on `trap_in` at an earlier clock edge and `trap_in` is still high at the sample point.
- R5: A hold request high at a sample point wins over every interrupt, including the trap. `hold_gnt` is 1 until the cycle after `hold_req_in` drops. A trap still pending is then taken at the next sample point.
- R6: A rising edge on `rq75_in` sets a pending latch that does not need the input to stay high. The latch is cleared when R7.5 is taken, or by a mask write with bit 4 set. If a new edge arrives in the same cycle as a clear, the new edge wins. `stat_byte` bit 6 shows the latch.
- R7: R6.5, R5.5 and the general request are taken only if they are high at the sample point. A pulse that ends before the sample point is lost.
- R8: The global enable (`stat_byte` bit 3) is cleared by reset, by `dis_cmd` and by any recognition, including the trap. It is set only by `en_cmd`. When both commands arrive together, `dis_cmd` wins.
- R9: A mask write with bit 3 set loads bits 2:0 as the masks for R7.5, R6.5 and R5.5 (1 = blocked). With bit 3 clear, the masks are unchanged. `stat_byte` bits 2:0 show the masks. Bits 5 and 4 show the raw R6.5 and R5.5 levels, whether masked or not.
- R10: When the general request wins, `inta_n` is 0 for one cycle. It stays 0 one more cycle for each cycle that `ack_more` is 1, up to `MAX_ACK` cycles in total (default 3).
- R11: Taking the trap clears its edge latch. A trap input held high does not cause a second recognition until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_pt | input | 1 | Instruction-boundary sample strobe from the core |
| trap_in | input | 1 | Non-maskable trap request |
| rq75_in | input | 1 | Edge-triggered restart request R7.5 |
| rq65_in | input | 1 | Level restart request R6.5 |
| rq55_in | input | 1 | Level restart request R5.5 |
| gen_req_in | input | 1 | Level general request without a vector |
| hold_req_in | input | 1 | Bus-hold request |
| en_cmd | input | 1 | Enable command (sets global enable) |
| dis_cmd | input | 1 | Disable command (clears global enable) |
| mask_wr | input | 1 | Set-mask write strobe |
| mask_data | input | 8 | Set-mask byte: bit 4 clears R7.5 latch, bit 3 mask load, bits 2:0 masks R7.5/R6.5/R5.5 |
| ack_more | input | 1 | Core requests another acknowledge cycle for a further opcode byte |
| vec_vld | output | 1 | One-cycle pulse: vectored request taken |
| vec_addr | output | VEC_W | Vector address of the last taken request |
| inta_n | output | 1 | Active-low acknowledge for the general request |
| hold_gnt | output | 1 | Bus hold granted |
| stat_byte | output | 8 | Status: bit 6 R7.5 latch, bits 5:4 R6.5/R5.5 levels, bit 3 enable, bits 2:0 masks |

## Verification
The assertions assume that `sample_pt` is raised only at instruction boundaries, that `ack_more` is meaningful only during acknowledge cycles, and that the level requests are held steady around each clock edge. The directed stimulus changes every input on the falling clock edge. It raises the sample strobe for exactly one cycle at a time and keeps `ack_more` low outside the acknowledge scenarios. The properties on the hold grant, the source of the acknowledge and the vector pulse therefore see only the input sequences that a real core would produce.

// File: rtl/vint_pkg.sv
package vint_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_ACK  = 2'd2
    } ctl_state_e;

    // vectored sources in priority order, index 0 highest
    localparam int VREQ_N   = 4;
    localparam int IDX_TRAP = 0;
    localparam int IDX_R75  = 1;
    localparam int IDX_R65  = 2;
    localparam int IDX_R55  = 3;

    // restart number doubled so that half steps stay integral
    function automatic int restart_dbl(input int idx);
        case (idx)
            IDX_TRAP: return 9;
            IDX_R75:  return 15;
            IDX_R65:  return 13;
            default:  return 11;
        endcase
    endfunction

endpackage

// File: rtl/vint_edge_latch.sv
module vint_edge_latch #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    logic [W-1:0] prev_q;

    generate
        for (genvar i = 0; i < W; i++) begin : g_lane
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    // start high so a line held high through reset is no edge
                    prev_q[i] <= 1'b1;
                    pend[i]   <= 1'b0;
                end else begin
                    prev_q[i] <= din[i];
                    // a fresh edge wins over a clear in the same cycle
                    pend[i]   <= (pend[i] & ~clr[i]) | (din[i] & ~prev_q[i]);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/vint_gate.sv
module vint_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_cmd,
    input  logic       dis_cmd,
    input  logic       recog,
    input  logic       mask_wr,
    input  logic       mask_load,
    input  logic [2:0] mask_bits,
    input  logic       trap_pend,
    input  logic       trap_lvl,
    input  logic       r75_pend,
    input  logic       r65_lvl,
    input  logic       r55_lvl,
    input  logic       gen_lvl,
    output logic [3:0] elig,
    output logic       gen_ok,
    output logic       ie,
    output logic [2:0] masks
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie    <= 1'b0;
            masks <= 3'b111;
        end else begin
            if (recog)
                ie <= 1'b0;
            else if (dis_cmd)
                ie <= 1'b0;
            else if (en_cmd)
                ie <= 1'b1;
            if (mask_wr && mask_load)
                masks <= mask_bits;
        end
    end

    always_comb begin
        // trap: edge seen and level still present, no enable or mask
        elig[0] = trap_pend & trap_lvl;
        elig[1] = ie & ~masks[2] & r75_pend;
        elig[2] = ie & ~masks[1] & r65_lvl;
        elig[3] = ie & ~masks[0] & r55_lvl;
        gen_ok  = ie & gen_lvl;
    end

endmodule

// File: rtl/vint_prio.sv
module vint_prio
    import vint_pkg::*;
#(
    parameter int VEC_W  = 16,
    parameter int STRIDE = 8
) (
    input  logic [VREQ_N-1:0] vreq,
    input  logic              gen_req,
    output logic [VREQ_N-1:0] grant,
    output logic              gen_win,
    output logic [VEC_W-1:0]  vec
);

    generate
        for (genvar i = 0; i < VREQ_N; i++) begin : g_grant
            if (i == 0) begin : g_top
                assign grant[i] = vreq[i];
            end else begin : g_rest
                assign grant[i] = vreq[i] & ~(|vreq[i-1:0]);
            end
        end
    endgenerate

    assign gen_win = gen_req & ~(|vreq);

    always_comb begin
        vec = '0;
        for (int i = 0; i < VREQ_N; i++) begin
            if (grant[i])
                vec = vec | VEC_W'(restart_dbl(i) * STRIDE / 2);
        end
    end

endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
#(
    parameter int VEC_W   = 16,
    parameter int STRIDE  = 8,
    parameter int MAX_ACK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_pt,
    input  logic             trap_in,
    input  logic             rq75_in,
    input  logic             rq65_in,
    input  logic             rq55_in,
    input  logic             gen_req_in,
    input  logic             hold_req_in,
    input  logic             en_cmd,
    input  logic             dis_cmd,
    input  logic             mask_wr,
    input  logic [7:0]       mask_data,
    input  logic             ack_more,
    output logic             vec_vld,
    output logic [VEC_W-1:0] vec_addr,
    output logic             inta_n,
    output logic             hold_gnt,
    output logic [7:0]       stat_byte
);

    localparam int CNT_W = $clog2(MAX_ACK + 1);

    ctl_state_e        state_q, state_nxt;
    logic [CNT_W-1:0]  ack_cnt_q, ack_cnt_nxt;
    logic              take_vec, take_gen;
    logic [1:0]        edge_pend, edge_clr;
    logic [VREQ_N-1:0] elig, grant;
    logic              gen_ok, gen_win, ie;
    logic [2:0]        masks;
    logic [VEC_W-1:0]  win_vec;
    logic              unused_hi;

    assign unused_hi = ^mask_data[7:5];

    // lane 0 trap, lane 1 R7.5
    assign edge_clr[0] = take_vec & grant[IDX_TRAP];
    assign edge_clr[1] = (take_vec & grant[IDX_R75]) | (mask_wr & mask_data[4]);

    vint_edge_latch #(.W(2)) i_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({rq75_in, trap_in}),
        .clr   (edge_clr),
        .pend  (edge_pend)
    );

    vint_gate i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_cmd    (en_cmd),
        .dis_cmd   (dis_cmd),
        .recog     (take_vec | take_gen),
        .mask_wr   (mask_wr),
        .mask_load (mask_data[3]),
        .mask_bits (mask_data[2:0]),
        .trap_pend (edge_pend[0]),
        .trap_lvl  (trap_in),
        .r75_pend  (edge_pend[1]),
        .r65_lvl   (rq65_in),
        .r55_lvl   (rq55_in),
        .gen_lvl   (gen_req_in),
        .elig      (elig),
        .gen_ok    (gen_ok),
        .ie        (ie),
        .masks     (masks)
    );

    vint_prio #(.VEC_W(VEC_W), .STRIDE(STRIDE)) i_prio (
        .vreq    (elig),
        .gen_req (gen_ok),
        .grant   (grant),
        .gen_win (gen_win),
        .vec     (win_vec)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            ack_cnt_q <= '0;
            vec_vld   <= 1'b0;
            vec_addr  <= '0;
        end else begin
            state_q   <= state_nxt;
            ack_cnt_q <= ack_cnt_nxt;
            vec_vld   <= take_vec;
            if (take_vec)
                vec_addr <= win_vec;
        end
    end

    // next state and recognition
    always_comb begin
        state_nxt   = state_q;
        ack_cnt_nxt = ack_cnt_q;
        take_vec    = 1'b0;
        take_gen    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (sample_pt) begin
                    if (hold_req_in) begin
                        state_nxt = S_HOLD;                 // IDLE_TO_HOLD
                    end else if (|grant) begin
                        take_vec = 1'b1;
                    end else if (gen_win) begin
                        take_gen    = 1'b1;
                        state_nxt   = S_ACK;                // IDLE_TO_ACK
                        ack_cnt_nxt = CNT_W'(1);
                    end
                end
            end
            S_HOLD: begin
                if (!hold_req_in)
                    state_nxt = S_IDLE;                     // HOLD_TO_IDLE
            end
            S_ACK: begin
                if (ack_more && (ack_cnt_q < CNT_W'(MAX_ACK))) begin
                    ack_cnt_nxt = ack_cnt_q + CNT_W'(1);    // ACK_STAY
                end else begin
                    state_nxt   = S_IDLE;                   // ACK_TO_IDLE
                    ack_cnt_nxt = '0;
                end
            end
            default: begin
                state_nxt   = S_IDLE;
                ack_cnt_nxt = '0;
            end
        endcase
    end

    // outputs decoded from state
    always_comb begin
        hold_gnt  = (state_q == S_HOLD);
        inta_n    = (state_q != S_ACK);
        stat_byte = {1'b0, edge_pend[1], rq65_in, rq55_in, ie, masks};
    end

endmodule

// File: rtl/vint_ctrl_chk.sv
module vint_ctrl_chk #(
    parameter int VEC_W   = 16,
    parameter int MAX_ACK = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_pt,
    input logic             trap_in,
    input logic             gen_req_in,
    input logic             hold_req_in,
    input logic             mask_wr,
    input logic             vec_vld,
    input logic [VEC_W-1:0] vec_addr,
    input logic             inta_n,
    input logic             hold_gnt,
    input logic [7:0]       stat_byte
);

    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= 0;
        else if (!inta_n)
            low_run <= low_run + 1;
        else
            low_run <= 0;
    end

    p_vec_at_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> $past(sample_pt));

    p_single_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vec_vld, !inta_n, hold_gnt}));

    p_hold_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_gnt |-> $past(hold_req_in));

    p_trap_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_vld && vec_addr == VEC_W'(36)) |-> $past(trap_in));

    p_enable_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> !stat_byte[3]);

    p_mask_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(stat_byte[2:0]));

    p_ack_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inta_n) |-> $past(gen_req_in && sample_pt));

    p_ack_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= MAX_ACK);

endmodule

bind vint_ctrl vint_ctrl_chk #(.VEC_W(VEC_W), .MAX_ACK(MAX_ACK)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_pt   (sample_pt),
    .trap_in     (trap_in),
    .gen_req_in  (gen_req_in),
    .hold_req_in (hold_req_in),
    .mask_wr     (mask_wr),
    .vec_vld     (vec_vld),
    .vec_addr    (vec_addr),
    .inta_n      (inta_n),
    .hold_gnt    (hold_gnt),
    .stat_byte   (stat_byte)
);

// File: tb/test_vint_ctrl.sv
module test_vint_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_pt = 0, trap_in = 0, rq75_in = 0, rq65_in = 0, rq55_in = 0;
    logic        gen_req_in = 0, hold_req_in = 0, en_cmd = 0, dis_cmd = 0;
    logic        mask_wr = 0, ack_more = 0;
    logic [7:0]  mask_data = 8'h00;
    logic        vec_vld, inta_n, hold_gnt;
    logic [15:0] vec_addr;
    logic [7:0]  stat_byte;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    vint_ctrl i_vint_ctrl (
        .clk(clk), .rst_n(rst_n), .sample_pt(sample_pt), .trap_in(trap_in),
        .rq75_in(rq75_in), .rq65_in(rq65_in), .rq55_in(rq55_in),
        .gen_req_in(gen_req_in), .hold_req_in(hold_req_in),
        .en_cmd(en_cmd), .dis_cmd(dis_cmd), .mask_wr(mask_wr),
        .mask_data(mask_data), .ack_more(ack_more), .vec_vld(vec_vld),
        .vec_addr(vec_addr), .inta_n(inta_n), .hold_gnt(hold_gnt),
        .stat_byte(stat_byte)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic smp();
        sample_pt = 1'b1;
        tick();
        sample_pt = 1'b0;
    endtask

    task automatic wr_mask(input logic [7:0] b);
        mask_wr = 1'b1;
        mask_data = b;
        tick();
        mask_wr = 1'b0;
    endtask

    task automatic do_en();
        en_cmd = 1'b1; tick(); en_cmd = 1'b0;
    endtask

    task automatic do_dis();
        dis_cmd = 1'b1; tick(); dis_cmd = 1'b0;
    endtask

    task automatic pulse75();
        rq75_in = 1'b1; tick(); rq75_in = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 vec_vld", vec_vld, 0);
        chk("R1 inta_n", inta_n, 1);
        chk("R1 hold_gnt", hold_gnt, 0);
        chk("R1 status", stat_byte, 8'h07);
    endtask

    task automatic t_sample_only();
        wr_mask(8'h08);
        do_en();
        rq55_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R2 no sample no take", vec_vld, 0);
        end
        smp();
        chk("R2 take at sample", vec_vld, 1);
        chk("R2 R3 vector R5.5", vec_addr, 16'h002C);
        chk("R8 enable cleared on take", stat_byte[3], 0);
        tick();
        chk("R2 single pulse", vec_vld, 0);
        rq55_in = 1'b0;
    endtask

    task automatic t_priority();
        do_en();
        rq65_in = 1'b1; rq55_in = 1'b1; gen_req_in = 1'b1;
        pulse75();
        smp();
        chk("R3 R7.5 first", vec_addr, 16'h003C);
        do_en();
        smp();
        chk("R3 R6.5 second", vec_addr, 16'h0034);
        rq65_in = 1'b0;
        do_en();
        smp();
        chk("R3 R5.5 third", vec_addr, 16'h002C);
        rq55_in = 1'b0;
        do_en();
        smp();
        chk("R3 general last vld", vec_vld, 0);
        chk("R3 general ack", inta_n, 0);
        tick();
        chk("R10 one ack cycle", inta_n, 1);
        gen_req_in = 1'b0;
    endtask

    task automatic t_trap();
        do_dis();
        wr_mask(8'h0F);
        trap_in = 1'b1;
        tick();
        smp();
        chk("R4 trap despite masks", vec_vld, 1);
        chk("R4 trap vector", vec_addr, 16'h0024);
        chk("R8 trap clears enable", stat_byte[3], 0);
        smp();
        chk("R11 held trap not retaken", vec_vld, 0);
        trap_in = 1'b0;
        tick();
        trap_in = 1'b1; tick(); tick(); trap_in = 1'b0; tick();
        smp();
        chk("R4 trap fell before sample", vec_vld, 0);
        wr_mask(8'h08);
        do_en();
        rq65_in = 1'b1;
        trap_in = 1'b1;
        tick();
        smp();
        chk("R3 trap over R6.5", vec_addr, 16'h0024);
        smp();
        chk("R8 R6.5 blocked after recognition", vec_vld, 0);
        rq65_in = 1'b0; trap_in = 1'b0;
        tick();
    endtask

    task automatic t_hold();
        trap_in = 1'b1;
        tick();
        hold_req_in = 1'b1;
        smp();
        chk("R5 hold granted", hold_gnt, 1);
        chk("R5 trap deferred", vec_vld, 0);
        smp();
        chk("R5 hold kept", hold_gnt, 1);
        chk("R5 no take in hold", vec_vld, 0);
        hold_req_in = 1'b0;
        tick();
        chk("R5 hold released", hold_gnt, 0);
        smp();
        chk("R5 trap after hold", vec_addr, 16'h0024);
        chk("R5 trap after hold vld", vec_vld, 1);
        trap_in = 1'b0;
        tick();
    endtask

    task automatic t_r75();
        wr_mask(8'h08);
        do_en();
        pulse75();
        chk("R6 latch pending", stat_byte[6], 1);
        wr_mask(8'h10);
        chk("R6 latch cleared by mask byte", stat_byte[6], 0);
        chk("R9 masks kept without load bit", stat_byte[2:0], 0);
        smp();
        chk("R6 cleared latch not taken", vec_vld, 0);
        pulse75();
        smp();
        chk("R6 edge taken", vec_addr, 16'h003C);
        chk("R6 latch cleared by take", stat_byte[6], 0);
        wr_mask(8'h0C);
        do_en();
        pulse75();
        smp();
        chk("R9 masked R7.5 not taken", vec_vld, 0);
        chk("R9 masked R7.5 still pending", stat_byte[6], 1);
        wr_mask(8'h08);
        smp();
        chk("R6 taken after unmask", vec_addr, 16'h003C);
    endtask

    task automatic t_mask();
        wr_mask(8'h0B);
        chk("R9 masks loaded", stat_byte[2:0], 3'b011);
        wr_mask(8'h05);
        chk("R9 no load without bit 3", stat_byte[2:0], 3'b011);
        do_en();
        rq55_in = 1'b1;
        tick();
        smp();
        chk("R9 masked R5.5 ignored", vec_vld, 0);
        chk("R9 R5.5 level shown", stat_byte[4], 1);
        rq55_in = 1'b0;
        wr_mask(8'h08);
    endtask

    task automatic t_level();
        do_en();
        rq65_in = 1'b1; tick(); rq65_in = 1'b0; tick();
        smp();
        chk("R7 R6.5 pulse lost", vec_vld, 0);
        gen_req_in = 1'b1; tick(); gen_req_in = 1'b0;
        smp();
        chk("R7 general pulse lost", inta_n, 1);
    endtask

    task automatic t_ack();
        gen_req_in = 1'b1;
        ack_more = 1'b1;
        smp();
        chk("R10 ack 1", inta_n, 0);
        tick();
        chk("R10 ack 2", inta_n, 0);
        tick();
        chk("R10 ack 3", inta_n, 0);
        tick();
        chk("R10 ack limit", inta_n, 1);
        ack_more = 1'b0;
        do_en();
        smp();
        chk("R10 short ack 1", inta_n, 0);
        ack_more = 1'b1;
        tick();
        chk("R10 short ack 2", inta_n, 0);
        ack_more = 1'b0;
        tick();
        chk("R10 short ack end", inta_n, 1);
        gen_req_in = 1'b0;
    endtask

    task automatic t_enable();
        do_dis();
        chk("R8 disabled", stat_byte[3], 0);
        do_en();
        chk("R8 enabled", stat_byte[3], 1);
        en_cmd = 1'b1; dis_cmd = 1'b1; tick(); en_cmd = 1'b0; dis_cmd = 1'b0;
        chk("R8 disable wins", stat_byte[3], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sample_only();
        t_priority();
        t_trap();
        t_hold();
        t_r75();
        t_mask();
        t_level();
        t_ack();
        t_enable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule